// File: doc/BRIEF.md
# Virtual Segment Decoder with Fault Reporting

This block sorts each 32-bit virtual address from a processor's load/store path into its segment. It translates the segments that need no table directly and sends the others to an external translation-table lookup. The lookup answers in the same cycle. The block then returns the physical address and the read and write permission for the access, or it raises a fault. A fault is turned into an exception code, chosen by what went wrong and by whether the access is a read or a write.

Translation results are combinational and valid while `req_valid` is high. When a request faults, the exception code appears one clock later as a one-cycle pulse, together with three updated fault-status words:
- the faulting address;
- a context word that carries the address's page-pair number;
- an entry-high word that carries the same page-pair number next to the current 8-bit address-space identifier.

The caller supplies the current context and entry-high values, so that the bits the block does not replace are kept.

Top module: `vseg_decoder`

## Requirements
- R1: With `req_user`=1, any address with bit 31 set is a bad address. It raises code 4 on a read and code 5 on a write. It makes no table lookup and gives no translation.
- R2: Addresses 0x00000000..0x7FFFFFFF assert `tlb_lookup` and use the table result. One exception: when `req_errlvl` and `req_user` are both 1, the address passes through unchanged with read and write permission and no lookup.
- R3: Kernel addresses 0x80000000..0x9FFFFFFF translate to address minus 0x80000000, with read and write permission and no lookup.
- R4: Kernel addresses 0xA0000000..0xBFFFFFFF translate to address minus 0xA0000000, with read and write permission and no lookup.
- R5: Kernel addresses 0xC0000000..0xFFFFFFFF assert `tlb_lookup` and use the table result.
- R6: A table entry that matches and is valid, accessed by a read or with dirty=1, gives `xlat_ok`. It returns `tlb_paddr` with read permission, and write permission equal to the dirty bit.
- R7: A table miss raises code 2 on a read or code 3 on a write, with `exc_refill`=1.
- R8: A match whose entry is not valid raises code 2 on a read or code 3 on a write, with `exc_refill`=0.
- R9: A write to a valid entry with dirty=0 raises code 1, with `exc_refill`=0.
- R10: On a fault, `bad_vaddr` becomes the address. `context_out` becomes {context_in[31:23], addr[31:13], 4'b0000}. `entryhi_out` becomes {addr[31:13], 5'b00000, entryhi_in[7:0]}.
- R11: `exc_valid` is high in the cycle after each faulting request and low after every other cycle, including cycles with `req_valid`=0. The three status words hold their value when there is no fault.
- R12: Under reset, `exc_valid`, `exc_code`, `exc_refill` and the three status words are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | Access made in user mode |
| req_errlvl | input | 1 | Error-level state bit |
| tlb_match | input | 1 | Table entry matched |
| tlb_valid | input | 1 | Matched page valid |
| tlb_dirty | input | 1 | Matched page writable |
| tlb_paddr | input | 32 | Physical address from the table |
| context_in | input | 32 | Current context word |
| entryhi_in | input | 32 | Current entry-high word |
| tlb_lookup | output | 1 | Address is a mapped one and is looked up |
| xlat_ok | output | 1 | Translation succeeded |
| paddr | output | 32 | Physical address |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| exc_valid | output | 1 | One-cycle fault pulse |
| exc_code | output | 5 | Exception code |
| exc_refill | output | 1 | Fault was a table miss |
| bad_vaddr | output | 32 | Last faulting address |
| context_out | output | 32 | Updated context word |
| entryhi_out | output | 32 | Updated entry-high word |

## Verification
The assertions check properties on every cycle:
- a user access to the upper half is always rejected with code 4 or 5;
- the direct kernel windows only clear the top three address bits and never look anything up;
- the fault pulse follows every request that was rejected;
- the refill flag appears only with codes 2 and 3;
- the status words move only with a fault pulse and carry the address fields.

The bench shows what a property cannot:
- the priority between miss, invalid and dirty outcomes across segments;
- the error-level pass-through, and that a kernel access ignores it;
- back-to-back faults;
- that the unreplaced bits of the context and entry-high words come from the inputs.

// File: rtl/vseg_decoder.sv
module vseg_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic        req_errlvl,
  input  logic        tlb_match,
  input  logic        tlb_valid,
  input  logic        tlb_dirty,
  input  logic [31:0] tlb_paddr,
  input  logic [31:0] context_in,
  input  logic [31:0] entryhi_in,
  output logic        tlb_lookup,
  output logic        xlat_ok,
  output logic [31:0] paddr,
  output logic        perm_rd,
  output logic        perm_wr,
  output logic        exc_valid,
  output logic [4:0]  exc_code,
  output logic        exc_refill,
  output logic [31:0] bad_vaddr,
  output logic [31:0] context_out,
  output logic [31:0] entryhi_out
);

  logic direct_win, bad_addr, pass_thru, mapped, tlb_fail, fault;
  logic [4:0] code_nxt;

  assign direct_win = req_vaddr[31:30] == 2'b10 && !req_user;
  assign bad_addr   = req_user && req_vaddr[31];
  assign pass_thru  = !req_vaddr[31] && req_errlvl && req_user;
  assign mapped     = !bad_addr && !pass_thru && !direct_win;
  assign tlb_fail   = !tlb_match || !tlb_valid || (req_write && !tlb_dirty);
  assign fault      = req_valid && (bad_addr || (mapped && tlb_fail));

  assign tlb_lookup = req_valid && mapped;
  assign xlat_ok    = req_valid && !fault;
  assign perm_rd    = xlat_ok;
  assign perm_wr    = xlat_ok && (mapped ? tlb_dirty : 1'b1);

  always_comb begin
    if (direct_win)     paddr = {3'b000, req_vaddr[28:0]};
    else if (pass_thru) paddr = req_vaddr;
    else                paddr = tlb_paddr;
  end

  always_comb begin
    if (bad_addr)                       code_nxt = req_write ? 5'd5 : 5'd4;
    else if (!tlb_match || !tlb_valid)  code_nxt = req_write ? 5'd3 : 5'd2;
    else                                code_nxt = 5'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid   <= 1'b0;
      exc_code    <= '0;
      exc_refill  <= 1'b0;
      bad_vaddr   <= '0;
      context_out <= '0;
      entryhi_out <= '0;
    end else begin
      exc_valid <= fault;
      if (fault) begin
        exc_code    <= code_nxt;
        exc_refill  <= !bad_addr && !tlb_match;
        bad_vaddr   <= req_vaddr;
        context_out <= {context_in[31:23], req_vaddr[31:13], 4'b0000};
        entryhi_out <= {req_vaddr[31:13], 5'b00000, entryhi_in[7:0]};
      end
    end
  end

  a_r1_user_upper_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_user && req_vaddr[31] |-> !tlb_lookup && !xlat_ok
      ##1 exc_valid && (exc_code == 5'd4 || exc_code == 5'd5));

  a_r3_r4_direct_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_user && req_vaddr[31:30] == 2'b10 |->
      xlat_ok && perm_wr && !tlb_lookup && paddr == (req_vaddr & 32'h1FFF_FFFF));

  a_r5_upper_kernel_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_user && req_vaddr[31:30] == 2'b11 |-> tlb_lookup);

  a_r7_refill_codes: assert property (@(posedge clk) disable iff (!rst_n)
    exc_refill && exc_valid |-> exc_code == 5'd2 || exc_code == 5'd3);

  a_r10_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> context_out[22:4] == bad_vaddr[31:13]
      && entryhi_out[31:13] == bad_vaddr[31:13] && entryhi_out[12:8] == 5'd0);

  a_r11_hold_without_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> $stable(bad_vaddr) && $stable(context_out) && $stable(entryhi_out));

  a_r11_pulse_follows_reject: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xlat_ok |=> exc_valid);

endmodule

// File: tb/vseg_decoder_bench.sv
module vseg_decoder_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_user = 0, req_errlvl = 0;
  logic tlb_match = 0, tlb_valid = 0, tlb_dirty = 0;
  logic [31:0] req_vaddr = 0;
  localparam logic [31:0] TP = 32'h0ABC_D123;
  localparam logic [31:0] CTX = 32'hFF80_000F;
  localparam logic [31:0] EHI = 32'h0000_1F5A;
  logic tlb_lookup, xlat_ok, perm_rd, perm_wr, exc_valid, exc_refill;
  logic [31:0] paddr, bad_vaddr, context_out, entryhi_out;
  logic [4:0] exc_code;

  vseg_decoder u_vseg_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .req_errlvl(req_errlvl),
    .tlb_match(tlb_match), .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty),
    .tlb_paddr(TP), .context_in(CTX), .entryhi_in(EHI),
    .tlb_lookup(tlb_lookup), .xlat_ok(xlat_ok), .paddr(paddr),
    .perm_rd(perm_rd), .perm_wr(perm_wr), .exc_valid(exc_valid),
    .exc_code(exc_code), .exc_refill(exc_refill), .bad_vaddr(bad_vaddr),
    .context_out(context_out), .entryhi_out(entryhi_out));

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] a;
    logic w, u, e, m, v, d;
    logic ok;
    logic [31:0] pa;
    logic pw, lk, ex;
    logic [4:0] code;
    logic rf;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  32'h8000_1000, 0,0,0, 0,0,0, 1, 32'h0000_1000, 1,0,0, 5'd0,0}, // R3
    '{4'd3,  32'h9FFF_FFFC, 1,0,0, 0,0,0, 1, 32'h1FFF_FFFC, 1,0,0, 5'd0,0}, // R3
    '{4'd4,  32'hA000_0040, 0,0,0, 0,0,0, 1, 32'h0000_0040, 1,0,0, 5'd0,0}, // R4
    '{4'd4,  32'hBFFF_0000, 1,0,0, 0,0,0, 1, 32'h1FFF_0000, 1,0,0, 5'd0,0}, // R4
    '{4'd6,  32'h0040_0000, 0,1,0, 1,1,0, 1, TP,            0,1,0, 5'd0,0}, // R6
    '{4'd9,  32'h0040_0000, 1,1,0, 1,1,0, 0, 32'h0,         0,1,1, 5'd1,0}, // R9
    '{4'd6,  32'h0040_0000, 1,1,0, 1,1,1, 1, TP,            1,1,0, 5'd0,0}, // R6
    '{4'd7,  32'h7FFF_F000, 0,1,0, 0,0,0, 0, 32'h0,         0,1,1, 5'd2,1}, // R7
    '{4'd7,  32'h7FFF_F000, 1,1,0, 0,0,0, 0, 32'h0,         0,1,1, 5'd3,1}, // R7
    '{4'd8,  32'h1000_0000, 0,0,0, 1,0,1, 0, 32'h0,         0,1,1, 5'd2,0}, // R8
    '{4'd8,  32'h1000_0000, 1,0,0, 1,0,1, 0, 32'h0,         0,1,1, 5'd3,0}, // R8
    '{4'd1,  32'h8000_0000, 0,1,0, 1,1,1, 0, 32'h0,         0,0,1, 5'd4,0}, // R1
    '{4'd1,  32'hC000_0000, 1,1,0, 1,1,1, 0, 32'h0,         0,0,1, 5'd5,0}, // R1
    '{4'd2,  32'h0000_2000, 0,1,1, 0,0,0, 1, 32'h0000_2000, 1,0,0, 5'd0,0}, // R2
    '{4'd2,  32'h0000_2000, 0,0,1, 0,0,0, 0, 32'h0,         0,1,1, 5'd2,1}, // R2
    '{4'd5,  32'hC000_0000, 0,0,0, 1,1,1, 1, TP,            1,1,0, 5'd0,0}, // R5
    '{4'd5,  32'hE000_1234, 1,0,0, 0,0,0, 0, 32'h0,         0,1,1, 5'd3,1}, // R5
    '{4'd1,  32'hFFFF_FFFF, 1,1,1, 0,0,0, 0, 32'h0,         0,0,1, 5'd5,0}  // R1
  };

  int checks = 0, fails = 0;
  logic [31:0] last_bad = 0, last_ctx = 0, last_ehi = 0;

  task automatic chk(input bit good, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic w, u, e, m, v, d, input logic vld);
    @(negedge clk);
    req_valid = vld; req_vaddr = a; req_write = w; req_user = u; req_errlvl = e;
    tlb_match = m; tlb_valid = v; tlb_dirty = d;
    #1;
  endtask

  task automatic check_regs(input string rq, input logic fault, input logic [31:0] a,
                            input logic [4:0] code, input logic rf);
    logic [31:0] ectx, eehi;
    @(posedge clk); #1;
    if (fault) begin
      last_bad = a;
      last_ctx = {CTX[31:23], a[31:13], 4'b0000};
      last_ehi = {a[31:13], 5'b00000, EHI[7:0]};
    end
    ectx = last_ctx; eehi = last_ehi;
    chk(exc_valid == fault && (!fault || (exc_code == code && exc_refill == rf)),
        rq, "exc valid/code/refill", {exc_valid, exc_code, exc_refill}, {fault, code, rf});
    chk(bad_vaddr == last_bad && context_out == ectx && entryhi_out == eehi,
        "R10/R11", "status words", {bad_vaddr, context_out}, {last_bad, ectx});
  endtask

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk(!exc_valid && exc_code == 0 && !exc_refill && bad_vaddr == 0
        && context_out == 0 && entryhi_out == 0, "R12", "reset state",
        {exc_valid, exc_code, bad_vaddr}, 64'h0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      vec_t t = VECS[i];
      string rq = $sformatf("R%0d", t.rq);
      drive(t.a, t.w, t.u, t.e, t.m, t.v, t.d, 1'b1);
      chk(xlat_ok == t.ok && tlb_lookup == t.lk, rq, "ok/lookup",
          {xlat_ok, tlb_lookup}, {t.ok, t.lk});
      if (t.ok)
        chk(paddr == t.pa && perm_rd && perm_wr == t.pw, rq, "paddr/perm",
            {perm_wr, paddr}, {t.pw, t.pa});
      check_regs(rq, t.ex, t.a, t.code, t.rf);
    end

    // R11: invalid request with faulting inputs has no effect
    drive(32'hF000_0000, 1, 1, 0, 0, 0, 0, 1'b0);
    chk(!tlb_lookup && !xlat_ok, "R11", "idle lookup/ok", {tlb_lookup, xlat_ok}, 0);
    check_regs("R11", 1'b0, 32'h0, 5'd0, 1'b0);

    // R11: back-to-back faults pulse in both cycles
    drive(32'h0123_4000, 0, 0, 0, 0, 0, 0, 1'b1);
    check_regs("R11", 1'b1, 32'h0123_4000, 5'd2, 1'b1);
    drive(32'h8765_E000, 0, 1, 0, 0, 0, 0, 1'b1);
    check_regs("R11", 1'b1, 32'h8765_E000, 5'd4, 1'b0);

    // R11: a good translation after a fault drops the pulse and holds the words
    drive(32'h8000_0010, 0, 0, 0, 0, 0, 0, 1'b1);
    check_regs("R11", 1'b0, 32'h0, 5'd0, 1'b0);

    // R9: a read of a clean valid page is not a dirty fault
    drive(32'hD000_0000, 0, 0, 0, 1, 1, 0, 1'b1);
    chk(xlat_ok && !perm_wr && paddr == TP, "R9", "clean read",
        {xlat_ok, perm_wr, paddr}, {1'b1, 1'b0, TP});
    check_regs("R9", 1'b0, 32'h0, 5'd0, 1'b0);

    // R12: reset clears status again
    @(negedge clk); req_valid = 0; rst_n = 0;
    @(posedge clk); #1;
    chk(!exc_valid && bad_vaddr == 0 && context_out == 0 && entryhi_out == 0,
        "R12", "re-reset", {exc_valid, bad_vaddr}, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule